// File: doc/BRIEF.md
# Pipelined 8b/10b Encoder with Comma Idle Fill

The block turns a stream of bytes into DC-balanced 10-bit line code words. Each byte comes with a control flag. With the flag low the byte is a data character. With the flag high it is a special character. The encoder splits every byte into a 5-bit and a 3-bit part. It maps them to 6-bit and 4-bit sub-blocks and complements a sub-block whenever the running disparity calls for it. The disparity is carried from word to word.

A word is accepted only in cycles where the enable input is high. In the other cycles the block can fill the line with K28.5 comma characters, or it can output nothing. A force input lets an external disparity value replace the internal one for a given word. Two disparity outputs, one of them a cycle ahead of the other, let several encoders be chained. Requests for a special character that has no legal code raise an error flag that travels with the word.

Top module: `enc8b10b_idle`

## Requirements
- R1: Each input cycle reaches the outputs exactly three clock edges later: inputs present before edge n appear on `code_o`, `vld_o`, `ctl_err_o` and `rd_o` after edge n+2.
- R2: Driving `rst_ni` low clears every register at once, without a clock: `code_o`=0, `vld_o`=0, `ctl_err_o`=0, and the running disparity is negative (`rd_o`=0, `rd_chain_o`=0).
- R3: With `en_i`=1 and `ctl_i`=0, input bits [4:0] (x) select the 6-bit sub-block and bits [7:5] (y) select the 4-bit sub-block of the standard D.x.y code. The output is packed as `code_o[9:4]`=abcdei, with a in bit 9, and `code_o[3:0]`=fghj, with f in bit 3. Every emitted word holds 4, 5 or 6 ones.
- R4: Each sub-block is emitted in its negative-disparity form when the disparity in front of it is negative. When that disparity is positive, the sub-block is complemented if it is unbalanced, or if it is D.7 (6-bit) or D.x.3 (4-bit). Each unbalanced sub-block flips the disparity.
- R5: For D.x.7 the alternate 4-bit code (0111 at negative, 1000 at positive) is used when the disparity ahead of the 4-bit block is negative and x is 17, 18 or 20, or when it is positive and x is 11, 13 or 14. In all other cases D.x.7 uses 1110 or 0001.
- R6: With `en_i`=1 and `ctl_i`=1, the bytes K28.0 to K28.7 (0x1C, 0x3C, ... 0xFC), K23.7 (0xF7), K27.7 (0xFB), K29.7 (0xFD) and K30.7 (0xFE) are encoded as special characters. Their 4-bit block is complemented whenever the disparity ahead of it is positive.
- R7: With `en_i`=1 and `ctl_i`=1 and any other byte, `ctl_err_o` is high together with the word, and the byte is encoded as a data character. `ctl_err_o` is never high without `vld_o`.
- R8: With `en_i`=0 and `idle_ins_i`=1, a K28.5 word is emitted with `vld_o`=1: 0011111010 at negative disparity and 1100000101 at positive. `byte_i` and `ctl_i` are ignored.
- R9: With `en_i`=0 and `idle_ins_i`=0, the resulting output cycle has `vld_o`=0, `code_o`=0 and `ctl_err_o`=0, and the disparity is held. `byte_i`, `ctl_i` and the force inputs have no effect in this case.
- R10: With `rd_force_i`=1 in a cycle that emits a word, `rd_ext_i` (1 = positive) replaces the tracked disparity as the starting disparity of that word. Later words continue from the disparity that results.
- R11: `rd_o` is the running disparity after the word on `code_o` (1 = positive). It stays unchanged through cycles with `vld_o`=0.
- R12: `rd_chain_o` gives, one cycle early, the value that `rd_o` will take after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Encode the byte on `byte_i` this cycle |
| ctl_i | input | 1 | Byte is a special (K) character |
| idle_ins_i | input | 1 | Emit K28.5 fill when `en_i` is low |
| byte_i | input | 8 | Input byte, y in [7:5], x in [4:0] |
| rd_ext_i | input | 1 | External starting disparity, 1 = positive |
| rd_force_i | input | 1 | Use `rd_ext_i` instead of the tracked disparity |
| code_o | output | 10 | Code word abcdei fghj, a in bit 9 |
| vld_o | output | 1 | `code_o` holds a word |
| ctl_err_o | output | 1 | Illegal special character requested for this word |
| rd_o | output | 1 | Disparity after the word on `code_o` |
| rd_chain_o | output | 1 | Disparity `rd_o` takes after the next edge |

## Verification
The hardest cases to reach are the disparity-dependent ones: the alternate D.x.7 form and the complemented 4-bit block of special characters. Each of them needs a particular disparity at the point between the two sub-blocks, and that disparity depends on the whole history of the stream. The bench reaches them by sweeping all 256 bytes, both as data and as special characters, once with the force input pinning the starting disparity to negative and once pinning it to positive. Free-running sweeps in a scrambled byte order follow, so that the tracked disparity, not only the forced one, goes through both branches. Fill gaps with junk on the inputs and a reset in the middle of the stream are placed between the sweeps.

// File: rtl/enc8b10b_pkg.sv
package enc8b10b_pkg;
  localparam int BYTE_W = 8;
  localparam int X_W    = 5;
  localparam int Y_W    = BYTE_W - X_W;
  localparam int S6_W   = X_W + 1;
  localparam int S4_W   = Y_W + 1;
  localparam int CODE_W = S6_W + S4_W;

  typedef struct packed {
    logic              vld;
    logic              k;
    logic              err;
    logic [BYTE_W-1:0] dat;
    logic              frc;
    logic              ext;
  } s1_t;

  typedef struct packed {
    logic            vld;
    logic            err;
    logic            k;
    logic [S6_W-1:0] raw6;
    logic            flip6;
    logic            unb6;
    logic [Y_W-1:0]  y;
    logic [S4_W-1:0] raw4;
    logic            a7n;
    logic            a7p;
    logic            frc;
    logic            ext;
  } s2_t;

  // negative-disparity form, abcdei with a in the msb
  function automatic logic [S6_W-1:0] sub6(input logic [X_W-1:0] x);
    unique case (x)
      5'd0:  return 6'b100111;  5'd1:  return 6'b011101;
      5'd2:  return 6'b101101;  5'd3:  return 6'b110001;
      5'd4:  return 6'b110101;  5'd5:  return 6'b101001;
      5'd6:  return 6'b011001;  5'd7:  return 6'b111000;
      5'd8:  return 6'b111001;  5'd9:  return 6'b100101;
      5'd10: return 6'b010101;  5'd11: return 6'b110100;
      5'd12: return 6'b001101;  5'd13: return 6'b101100;
      5'd14: return 6'b011100;  5'd15: return 6'b010111;
      5'd16: return 6'b011011;  5'd17: return 6'b100011;
      5'd18: return 6'b010011;  5'd19: return 6'b110010;
      5'd20: return 6'b001011;  5'd21: return 6'b101010;
      5'd22: return 6'b011010;  5'd23: return 6'b111010;
      5'd24: return 6'b110011;  5'd25: return 6'b100110;
      5'd26: return 6'b010110;  5'd27: return 6'b110110;
      5'd28: return 6'b001110;  5'd29: return 6'b101110;
      5'd30: return 6'b011110;  default: return 6'b101011;
    endcase
  endfunction

  // negative-disparity form, fghj; y=7 gives the primary form
  function automatic logic [S4_W-1:0] sub4(input logic [Y_W-1:0] y, input logic k);
    logic [S4_W-1:0] r;
    unique case (y)
      3'd0: r = 4'b1011;  3'd1: r = 4'b1001;
      3'd2: r = 4'b0101;  3'd3: r = 4'b1100;
      3'd4: r = 4'b1101;  3'd5: r = 4'b1010;
      3'd6: r = 4'b0110;  default: r = k ? 4'b0111 : 4'b1110;
    endcase
    if (k && (y == 3'd1 || y == 3'd2 || y == 3'd5 || y == 3'd6)) r = ~r;
    return r;
  endfunction

  function automatic logic k_legal(input logic [BYTE_W-1:0] b);
    logic [X_W-1:0] x;
    x = b[X_W-1:0];
    return (x == 5'd28) ||
           ((b[BYTE_W-1:X_W] == 3'd7) &&
            (x == 5'd23 || x == 5'd27 || x == 5'd29 || x == 5'd30));
  endfunction
endpackage

// File: rtl/enc_in_stage.sv
module enc_in_stage
  import enc8b10b_pkg::*;
#(
  parameter logic [BYTE_W-1:0] IDLE_CHAR = 8'hBC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              ctl_i,
  input  logic              idle_ins_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              rd_ext_i,
  input  logic              rd_force_i,
  output s1_t               s1_o
);
  s1_t s1_q;
  logic ok;

  assign ok = k_legal(byte_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
    end else begin
      s1_q.vld <= en_i | idle_ins_i;
      s1_q.frc <= (en_i | idle_ins_i) & rd_force_i;
      s1_q.ext <= (en_i | idle_ins_i) & rd_ext_i;
      if (en_i) begin
        s1_q.k   <= ctl_i & ok;
        s1_q.err <= ctl_i & ~ok;
        s1_q.dat <= byte_i;
      end else if (idle_ins_i) begin
        s1_q.k   <= 1'b1;
        s1_q.err <= 1'b0;
        s1_q.dat <= IDLE_CHAR;
      end else begin
        s1_q.k   <= 1'b0;
        s1_q.err <= 1'b0;
        s1_q.dat <= '0;
      end
    end
  end

  assign s1_o = s1_q;

  // R7
  err_only_valid_s1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_q.err |-> (s1_q.vld && !s1_q.k));
endmodule

// File: rtl/enc_lut_stage.sv
module enc_lut_stage
  import enc8b10b_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  s1_t  s1_i,
  output s2_t  s2_o
);
  logic [X_W-1:0]  x;
  logic [Y_W-1:0]  y;
  logic [S6_W-1:0] raw6;
  logic            unb6;
  s2_t             s2_q;

  assign x = s1_i.dat[X_W-1:0];
  assign y = s1_i.dat[BYTE_W-1:X_W];

  always_comb begin
    raw6 = (s1_i.k && x == 5'd28) ? 6'b001111 : sub6(x);
    unb6 = ($countones(raw6) != 3);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_q <= '0;
    end else begin
      s2_q.vld   <= s1_i.vld;
      s2_q.err   <= s1_i.err;
      s2_q.k     <= s1_i.k;
      s2_q.raw6  <= raw6;
      s2_q.unb6  <= unb6;
      s2_q.flip6 <= unb6 | (raw6 == 6'b111000);
      s2_q.y     <= y;
      s2_q.raw4  <= sub4(y, s1_i.k);
      s2_q.a7n   <= ~s1_i.k & (x == 5'd17 || x == 5'd18 || x == 5'd20);
      s2_q.a7p   <= ~s1_i.k & (x == 5'd11 || x == 5'd13 || x == 5'd14);
      s2_q.frc   <= s1_i.frc;
      s2_q.ext   <= s1_i.ext;
    end
  end

  assign s2_o = s2_q;

  // R3
  raw6_weight_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s2_q.vld |-> ($countones(s2_q.raw6) == 3 || $countones(s2_q.raw6) == 4));
endmodule

// File: rtl/enc_rd_stage.sv
module enc_rd_stage
  import enc8b10b_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  s2_t               s2_i,
  output logic [CODE_W-1:0] code_o,
  output logic              vld_o,
  output logic              err_o,
  output logic              rd_o,
  output logic              rd_chain_o
);
  logic              rd_q, vld_q, err_q;
  logic [CODE_W-1:0] code_q;
  logic              rd_in, rd_mid, rd_end, use_alt, flip4, unb4;
  logic [S6_W-1:0]   c6;
  logic [S4_W-1:0]   r4, c4;

  always_comb begin
    rd_in   = s2_i.frc ? s2_i.ext : rd_q;
    c6      = (rd_in & s2_i.flip6) ? ~s2_i.raw6 : s2_i.raw6;
    rd_mid  = rd_in ^ s2_i.unb6;
    use_alt = (s2_i.y == 3'd7) &
              (s2_i.k | (~rd_mid & s2_i.a7n) | (rd_mid & s2_i.a7p));
    r4      = use_alt ? 4'b0111 : s2_i.raw4;
    unb4    = (s2_i.y == 3'd0) | (s2_i.y == 3'd4) | (s2_i.y == 3'd7);
    flip4   = s2_i.k | unb4 | (s2_i.y == 3'd3);
    c4      = (rd_mid & flip4) ? ~r4 : r4;
    rd_end  = rd_mid ^ unb4;
  end

  assign rd_chain_o = s2_i.vld ? rd_end : rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= 1'b0;
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
      code_q <= '0;
    end else begin
      rd_q   <= rd_chain_o;
      vld_q  <= s2_i.vld;
      err_q  <= s2_i.err;
      code_q <= s2_i.vld ? {c6, c4} : '0;
    end
  end

  assign code_o = code_q;
  assign vld_o  = vld_q;
  assign err_o  = err_q;
  assign rd_o   = rd_q;

  // R3
  code_weight_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> ($countones(code_o) >= 4 && $countones(code_o) <= 6));
  // R4
  heavy_ends_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && $countones(code_o) == 6) |-> rd_o);
  // R4
  light_ends_neg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && $countones(code_o) == 4) |-> !rd_o);
  // R9
  gap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_o |-> (code_o == '0 && !err_o));
  // R11
  gap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_o |-> (rd_o == $past(rd_o)));
endmodule

// File: rtl/enc8b10b_idle.sv
module enc8b10b_idle
  import enc8b10b_pkg::*;
#(
  parameter logic [7:0] IDLE_CHAR = 8'hBC
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       ctl_i,
  input  logic       idle_ins_i,
  input  logic [7:0] byte_i,
  input  logic       rd_ext_i,
  input  logic       rd_force_i,
  output logic [9:0] code_o,
  output logic       vld_o,
  output logic       ctl_err_o,
  output logic       rd_o,
  output logic       rd_chain_o
);
  s1_t s1;
  s2_t s2;

  enc_in_stage #(.IDLE_CHAR(IDLE_CHAR)) u_in (
    .clk_i, .rst_ni, .en_i, .ctl_i, .idle_ins_i, .byte_i,
    .rd_ext_i, .rd_force_i, .s1_o(s1)
  );

  enc_lut_stage u_lut (.clk_i, .rst_ni, .s1_i(s1), .s2_o(s2));

  enc_rd_stage u_rd (
    .clk_i, .rst_ni, .s2_i(s2), .code_o, .vld_o, .err_o(ctl_err_o),
    .rd_o, .rd_chain_o
  );

  // R7
  err_implies_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_err_o |-> vld_o);
endmodule

// File: tb/enc8b10b_idle_tb_top.sv
module enc8b10b_idle_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic       rst_n, en, ctl, idle, frc, ext;
  logic [7:0] din;
  logic [9:0] code;
  logic       vld, err, rd, rdc;

  enc8b10b_idle dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .ctl_i(ctl), .idle_ins_i(idle),
    .byte_i(din), .rd_ext_i(ext), .rd_force_i(frc), .code_o(code),
    .vld_o(vld), .ctl_err_o(err), .rd_o(rd), .rd_chain_o(rdc)
  );

  localparam logic [5:0] T6 [0:31] = '{
    6'o47, 6'o35, 6'o55, 6'o61, 6'o65, 6'o51, 6'o31, 6'o70,
    6'o71, 6'o45, 6'o25, 6'o64, 6'o15, 6'o54, 6'o34, 6'o27,
    6'o33, 6'o43, 6'o23, 6'o62, 6'o13, 6'o52, 6'o32, 6'o72,
    6'o63, 6'o46, 6'o26, 6'o66, 6'o16, 6'o56, 6'o36, 6'o53};

  int checks = 0, fails = 0;
  logic mrd;
  logic       p_vld [3];
  logic [9:0] p_code[3];
  logic       p_rd  [3];
  logic       p_err [3];
  string      p_tag [3];

  function automatic logic legal_k(input logic [7:0] b);
    int x = int'(b[4:0]);
    return x == 28 || (b[7:5] == 3'd7 && (x == 23 || x == 27 || x == 29 || x == 30));
  endfunction

  task automatic ref_enc(input logic [7:0] b, input logic k, input logic rdi,
                         output logic [9:0] c, output logic rdo);
    int x = int'(b[4:0]);
    int y = int'(b[7:5]);
    logic [5:0] s6;
    logic [3:0] s4;
    logic r = rdi;
    s6 = (k && x == 28) ? 6'b001111 : T6[x];
    if (r && ($countones(s6) != 3 || s6 == 6'b111000)) s6 = ~s6;
    if ($countones(s6) != 3) r = ~r;
    case (y)
      0: s4 = 4'b1011; 1: s4 = 4'b1001; 2: s4 = 4'b0101; 3: s4 = 4'b1100;
      4: s4 = 4'b1101; 5: s4 = 4'b1010; 6: s4 = 4'b0110;
      default: s4 = (k || (!r && (x == 17 || x == 18 || x == 20)) ||
                     (r && (x == 11 || x == 13 || x == 14))) ? 4'b0111 : 4'b1110;
    endcase
    if (k && (y == 1 || y == 2 || y == 5 || y == 6)) s4 = ~s4;
    if (r && (k || $countones(s4) != 2 || y == 3)) s4 = ~s4;
    if ($countones(s4) != 2) r = ~r;
    c = {s6, s4};
    rdo = r;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic clear_pipe();
    for (int i = 0; i < 3; i++) begin
      p_vld[i] = 0; p_code[i] = '0; p_rd[i] = 0; p_err[i] = 0; p_tag[i] = "R2";
    end
    mrd = 0;
  endtask

  task automatic step(input logic e, input logic il, input logic c, input logic [7:0] b,
                      input logic f, input logic xr, input string tag);
    logic [9:0] ec;
    logic er;
    @(negedge clk);
    // R1: outputs belong to the cycle driven three steps earlier
    chk({"R1 vld ", p_tag[2]}, 32'(vld), 32'(p_vld[2]));
    chk({"code ", p_tag[2]}, 32'(code), 32'(p_code[2]));
    chk({"R11 rd ", p_tag[2]}, 32'(rd), 32'(p_rd[2]));
    chk({"R7 err ", p_tag[2]}, 32'(err), 32'(p_err[2]));
    chk({"R12 rd_chain ", p_tag[1]}, 32'(rdc), 32'(p_rd[1]));
    for (int i = 2; i > 0; i--) begin
      p_vld[i] = p_vld[i-1]; p_code[i] = p_code[i-1]; p_rd[i] = p_rd[i-1];
      p_err[i] = p_err[i-1]; p_tag[i] = p_tag[i-1];
    end
    p_tag[0] = tag;
    if (e || il) begin
      ref_enc(e ? b : 8'hBC, e ? (c && legal_k(b)) : 1'b1, f ? xr : mrd, ec, er);
      mrd = er;
      p_vld[0] = 1; p_code[0] = ec; p_rd[0] = er; p_err[0] = e && c && !legal_k(b);
    end else begin
      p_vld[0] = 0; p_code[0] = '0; p_rd[0] = mrd; p_err[0] = 0;
    end
    en = e; idle = il; ctl = c; din = b; frc = f; ext = xr;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; en = 0; ctl = 0; idle = 0; din = '0; frc = 0; ext = 0;
    clear_pipe();
    repeat (3) @(negedge clk);
    // R2: reset state
    chk("R2 code", 32'(code), 0); chk("R2 vld", 32'(vld), 0);
    chk("R2 rd", 32'(rd), 0);     chk("R2 err", 32'(err), 0);
    chk("R2 rd_chain", 32'(rdc), 0);
    rst_n = 1;

    // R8: fill words with junk on the byte and control inputs
    step(0, 1, 1, 8'h55, 0, 0, "R8");
    step(0, 1, 0, 8'hA3, 0, 0, "R8");
    step(0, 0, 0, 8'h00, 0, 0, "R9");
    step(0, 0, 0, 8'h00, 0, 0, "R9");
    chk("R8 K28.5 from negative", 32'(code), 32'(10'b0011111010));
    step(0, 0, 0, 8'h00, 0, 0, "R9");
    chk("R8 K28.5 from positive", 32'(code), 32'(10'b1100000101));

    // R3 R4 R5 R10: every data byte from both forced start disparities
    for (int f = 0; f < 2; f++)
      for (int i = 0; i < 256; i++)
        step(1, 0, 0, 8'(i), 1, f[0], "R3 R4 R5 R10 data forced");

    // R3 R4 R5: free running, scrambled byte order
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < 256; i++)
        step(1, 0, 0, 8'((i * 37 + p * 101) & 255), 0, 0, "R3 R4 R5 data free");

    // R6 R7 R10: every byte as a control request, both forced disparities
    for (int f = 0; f < 2; f++)
      for (int i = 0; i < 256; i++)
        step(1, 0, 1, 8'(i), 1, f[0], "R6 R7 R10 control forced");

    // R9: gaps ignore byte, control and force; disparity held
    for (int i = 0; i < 6; i++) step(0, 0, 1, 8'(i * 45), 1, i[0], "R9 gap");

    // R6 R8 R10: legal specials and fill interleaved, tracked disparity
    for (int i = 0; i < 64; i++) begin
      logic [7:0] kb;
      kb = (i % 12 < 8) ? {3'(i % 12), 5'd28} : {3'd7, 5'((i % 12 == 8) ? 23 :
           (i % 12 == 9) ? 27 : (i % 12 == 10) ? 29 : 30)};
      step(1, 0, 1, kb, 0, 0, "R6 control free");
      if (i % 5 == 0) step(0, 1, 0, 8'hFF, i[1], i[2], "R8 R10 fill");
      if (i % 7 == 0) step(0, 0, 0, 8'h12, 0, 0, "R9 gap");
    end

    // R2: reset in the middle of a stream acts without a clock
    step(1, 0, 0, 8'hA5, 0, 0, "R3 pre-reset");
    step(1, 0, 0, 8'h0F, 1, 1, "R3 pre-reset");
    #1 rst_n = 0;
    #1;
    chk("R2 async code", 32'(code), 0); chk("R2 async vld", 32'(vld), 0);
    chk("R2 async rd", 32'(rd), 0);     chk("R2 async rd_chain", 32'(rdc), 0);
    en = 0; idle = 0; ctl = 0; din = '0; frc = 0; ext = 0;
    clear_pipe();
    @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 40; i++) step(1, 0, 0, 8'(i * 13 + 7), 0, 0, "R3 R4 after reset");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 8'h00, 0, 0, "R9 drain");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule